// File: doc/BRIEF.md
# Interrupt Controller with Two Periodic Reload Timers

This block collects three interrupt sources into one status register and drives a single level interrupt line towards a processor. The sources are a vertical-blank input and two periodic countdown timers. A small byte-wide register bus gives access to the status, pending and mask registers and to each timer's reload bytes and restart strobe. Software acknowledges a source by writing a one to its bit in the acknowledge (pending) register.

Each timer is a two-state machine. `TMR_IDLE` is entered at reset and whenever the restart strobe is written while the reload value is zero. `TMR_RUN` is entered when the strobe is written while the reload value is non-zero. In `TMR_RUN` the timer counts microsecond ticks and expires once per period. The reload value is the 16-bit {high byte, low byte} pair shifted right by one bit, and it is taken as a period in microseconds. Each timer has its own microsecond prescaler, which divides the system clock by `CLK_PER_US` and is cleared by the restart strobe.

Register offsets on `bus_addr_i`: 0 status, 1 pending/acknowledge, 2 mask, 3/4/5 timer 0 low byte / high byte / restart, 6/7/8 timer 1 low byte / high byte / restart. All other offsets read as zero and ignore writes.

Top module: `irqt_ctrl`

## Requirements
- R1: After reset, status reads 0x80, mask reads 0x80, pending reads 0x80, `irq_o` is low and both timers are in `TMR_IDLE`.
- R2: Reading status (offset 0) returns the stored bits with bit 1 forced to 0 and bit 7 forced to 1. Vertical blank owns bit 3, timer 0 owns bit 5 and timer 1 owns bit 6. Writes to offset 0 are ignored.
- R3: Reading pending (offset 1) returns status AND mask with bit 7 forced to 1.
- R4: Writing offset 1 clears every status bit written as 1 and leaves the other bits unchanged. If a source event lands in the same cycle as the clear, the event wins and its bit stays set.
- R5: Writing mask (offset 2) stores the written byte with bit 1 cleared and bit 7 set.
- R6: `irq_o` is high exactly while status AND mask has any of bits 0 to 6 set.
- R7: After a restart write with a non-zero reload N = {high, low} >> 1, the timer's status bit is set N×`CLK_PER_US` clocks after the write edge, and again every N×`CLK_PER_US` clocks after that.
- R8: A restart write whose reload N is zero (this includes {high, low} = 1) moves the timer to `TMR_IDLE`, and it sets no further status bits.
- R9: The low and high reload bytes read back as written. Writing them without a restart leaves the running period unchanged.
- R10: A rising edge on `vblank_i` sets status bit 3 once. Holding `vblank_i` high does not set the bit again after it is acknowledged.
- R11: The two timers run independently, each with its own reload and status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe, one cycle per write |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| vblank_i | input | 1 | Vertical-blank level; its rising edge is the event |
| irq_o | output | 1 | Level interrupt request |

## Verification
The timers are tried with several reload patterns. An even reload shows the halving of the reload value. A reload of one shows that a value which halves to zero stops the timer. A reload changed without a restart shows that the period is latched when the restart is written. Each expiry is checked one cycle before and one cycle at the expected edge, so an off-by-one in the prescaler or the counter shows up. The mask is tried with patterns that select, omit and try to set the forced bits, which separates the pending read from the interrupt line. The vertical-blank input is held high across an acknowledge and is raised in the same cycle as an acknowledge, which separates edge detection from level detection and shows which side wins a collision.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam int ADDR_W     = 4;
    localparam int REG_W      = 8;
    localparam int NUM_TIMERS = 2;

    // register offsets (timer block i starts at RA_T0_LO + 3*i)
    localparam logic [ADDR_W-1:0] RA_STATUS = 4'd0;
    localparam logic [ADDR_W-1:0] RA_PEND   = 4'd1;
    localparam logic [ADDR_W-1:0] RA_MASK   = 4'd2;
    localparam logic [ADDR_W-1:0] RA_T0_LO  = 4'd3;
    localparam int TMR_STRIDE = 3;

    // status bit positions
    localparam int BIT_VBL    = 3;
    localparam int BIT_TMR0   = 5;
    localparam int BIT_ALWAYS = 7;
    localparam int BIT_DEAD   = 1;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic logic [ADDR_W-1:0] tmr_addr(input int idx, input int slot);
        return RA_T0_LO + ADDR_W'(TMR_STRIDE * idx + slot);
    endfunction

endpackage

// File: rtl/irqt_tick.sv
module irqt_tick #(
    parameter int DIV = 125
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            if (cnt_q == LAST) cnt_q <= '0;
            else               cnt_q <= cnt_q + PW'(1);
        end
    end

    assign tick_o = en_i && !clr_i && (cnt_q == LAST);

endmodule

// File: rtl/irqt_timer.sv
module irqt_timer
    import irqt_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int CNT_W      = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             go_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expire_o,
    output logic             running_o
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, period_q;
    logic             tick;
    logic             reload_zero;

    assign reload_zero = (reload_i == '0);

    irqt_tick #(.DIV(CLK_PER_US)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (go_i),
        .en_i   (state_q == TMR_RUN),
        .tick_o (tick)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: if (go_i && !reload_zero) state_d = TMR_RUN;
            TMR_RUN:  if (go_i && reload_zero)  state_d = TMR_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= TMR_IDLE;
        else         state_q <= state_d;
    end

    // outputs
    always_comb begin
        running_o = 1'b0;
        expire_o  = 1'b0;
        unique case (state_q)
            TMR_IDLE: ;
            TMR_RUN: begin
                running_o = 1'b1;
                expire_o  = tick && (count_q == CNT_W'(1));
            end
        endcase
    end

    // datapath: period latched on restart, countdown on ticks
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q  <= '0;
            period_q <= '0;
        end else if (go_i) begin
            count_q  <= reload_i;
            period_q <= reload_i;
        end else if (expire_o) begin
            count_q  <= period_q;
        end else if (state_q == TMR_RUN && tick) begin
            count_q  <= count_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/irqt_status.sv
module irqt_status
    import irqt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [REG_W-1:0] set_i,
    input  logic             ack_we_i,
    input  logic [REG_W-1:0] ack_bits_i,
    output logic [REG_W-1:0] status_o
);
    logic [REG_W-1:0] keep;

    assign keep = ack_we_i ? ~ack_bits_i : '1;

    // a set in the same cycle as an acknowledge wins
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_o <= '0;
        else         status_o <= (status_o & keep) | set_i;
    end

endmodule

// File: rtl/irqt_ctrl.sv
module irqt_ctrl
    import irqt_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int RELOAD_W   = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    input  logic              vblank_i,
    output logic              irq_o
);
    localparam int HI_W  = RELOAD_W - REG_W;
    localparam int CNT_W = RELOAD_W - 1;
    localparam logic [REG_W-1:0] ALWAYS_MSK = REG_W'(1) << BIT_ALWAYS;
    localparam logic [REG_W-1:0] DEAD_MSK   = REG_W'(1) << BIT_DEAD;

    logic [REG_W-1:0]      status_q;
    logic [REG_W-1:0]      mask_q;
    logic [REG_W-1:0]      set_vec;
    logic                  vb_q;
    logic                  vb_rise;
    logic [NUM_TIMERS-1:0] tmr_expire;
    logic [NUM_TIMERS-1:0] tmr_run;
    logic [NUM_TIMERS-1:0] tmr_go;
    logic [NUM_TIMERS-1:0] tmr_zero;
    logic [REG_W-1:0]      lo_q [NUM_TIMERS];
    logic [HI_W-1:0]       hi_q [NUM_TIMERS];

    // vertical blank edge detector
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vb_q <= 1'b0;
        else         vb_q <= vblank_i;
    end
    assign vb_rise = vblank_i && !vb_q;

    // mask register: bit 7 pinned high, bit 1 pinned low
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= ALWAYS_MSK;
        end else if (bus_we_i && bus_addr_i == RA_MASK) begin
            mask_q <= (bus_wdata_i & ~DEAD_MSK) | ALWAYS_MSK;
        end
    end

    // timers
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        localparam logic [ADDR_W-1:0] A_LO = tmr_addr(i, 0);
        localparam logic [ADDR_W-1:0] A_HI = tmr_addr(i, 1);
        localparam logic [ADDR_W-1:0] A_GO = tmr_addr(i, 2);

        logic [RELOAD_W-1:0] full;
        logic [CNT_W-1:0]    reload;

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end else if (bus_we_i) begin
                if (bus_addr_i == A_LO) lo_q[i] <= bus_wdata_i;
                if (bus_addr_i == A_HI) hi_q[i] <= bus_wdata_i[HI_W-1:0];
            end
        end

        assign full        = {hi_q[i], lo_q[i]};
        assign reload      = full[RELOAD_W-1:1];
        assign tmr_go[i]   = bus_we_i && (bus_addr_i == A_GO);
        assign tmr_zero[i] = (reload == '0);

        irqt_timer #(.CLK_PER_US(CLK_PER_US), .CNT_W(CNT_W)) u_timer (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .go_i      (tmr_go[i]),
            .reload_i  (reload),
            .expire_o  (tmr_expire[i]),
            .running_o (tmr_run[i])
        );
    end

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_VBL] = vb_rise;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            set_vec[BIT_TMR0 + i] = tmr_expire[i];
        end
    end

    irqt_status u_status (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (set_vec),
        .ack_we_i   (bus_we_i && bus_addr_i == RA_PEND),
        .ack_bits_i (bus_wdata_i),
        .status_o   (status_q)
    );

    // read mux
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == RA_STATUS) bus_rdata_o = (status_q & ~DEAD_MSK) | ALWAYS_MSK;
        if (bus_addr_i == RA_PEND)   bus_rdata_o = (status_q & mask_q) | ALWAYS_MSK;
        if (bus_addr_i == RA_MASK)   bus_rdata_o = mask_q;
        for (int i = 0; i < NUM_TIMERS; i++) begin
            if (bus_addr_i == tmr_addr(i, 0)) bus_rdata_o = lo_q[i];
            if (bus_addr_i == tmr_addr(i, 1)) bus_rdata_o = REG_W'(hi_q[i]);
        end
    end

    assign irq_o = |(status_q & mask_q & ~ALWAYS_MSK);

endmodule

// File: rtl/irqt_ctrl_chk.sv
module irqt_ctrl_chk
    import irqt_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  we,
    input logic [ADDR_W-1:0]     addr,
    input logic [REG_W-1:0]      wdata,
    input logic                  vblank,
    input logic [REG_W-1:0]      status,
    input logic [REG_W-1:0]      mask,
    input logic [NUM_TIMERS-1:0] expire,
    input logic [NUM_TIMERS-1:0] running,
    input logic [NUM_TIMERS-1:0] go,
    input logic [NUM_TIMERS-1:0] zero
);
    assert_mask_pinned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask[BIT_ALWAYS] && !mask[BIT_DEAD]);

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == RA_PEND && !(|expire) && !vblank)
        |=> ((status & $past(wdata)) == '0));

    assert_zero_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go[0] && zero[0]) |=> !running[0]);

    assert_expire_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |=> status[BIT_TMR0]);

    assert_expire_sets_t1_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expire[1] |=> status[BIT_TMR0 + 1]);

    assert_vblank_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |=> status[BIT_VBL]);
endmodule

bind irqt_ctrl irqt_ctrl_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .we      (bus_we_i),
    .addr    (bus_addr_i),
    .wdata   (bus_wdata_i),
    .vblank  (vblank_i),
    .status  (status_q),
    .mask    (mask_q),
    .expire  (tmr_expire),
    .running (tmr_run),
    .go      (tmr_go),
    .zero    (tmr_zero)
);

// File: tb/irqt_ctrl_test.sv
`timescale 1ns/1ps
module irqt_ctrl_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       vblank = 1'b0;
    logic       irq;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irqt_ctrl #(.CLK_PER_US(DIV), .RELOAD_W(16)) uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .vblank_i(vblank), .irq_o(irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    // called at a negedge; the write commits at the next posedge
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(0, d); check("R1 status", d, 8'h80);
        rd(2, d); check("R1 mask", d, 8'h80);
        rd(1, d); check("R1 pending", d, 8'h80);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        wr(2, 8'h02); rd(2, d); check("R5 mask 0x02", d, 8'h80);
        wr(2, 8'h7F); rd(2, d); check("R5 mask 0x7F", d, 8'hFD);
        wr(0, 8'hFF); rd(0, d); check("R2 status write ignored", d, 8'h80);
    endtask

    task automatic t_timer0;
        logic [7:0] d;
        wr(2, 8'hFF);
        wr(3, 8'h06); wr(4, 8'h00);   // reload 3 us
        wr(5, 8'h00);
        waitc(3 * DIV - 1);
        rd(0, d); check("R7 t0 before first expiry", d, 8'h80);
        waitc(1);
        rd(0, d); check("R7 t0 first expiry", d, 8'hA0);
        check("R6 irq on t0", {7'd0, irq}, 8'h01);
        wr(1, 8'h20);
        rd(0, d); check("R4 ack clears t0", d, 8'h80);
        check("R6 irq low after ack", {7'd0, irq}, 8'h00);
        waitc(3 * DIV - 2);
        rd(0, d); check("R7 t0 before second expiry", d, 8'h80);
        waitc(1);
        rd(0, d); check("R7 t0 periodic expiry", d, 8'hA0);
        wr(3, 8'h01); wr(5, 8'h00);   // {0,1} >> 1 == 0 stops
        wr(1, 8'hFF);
        waitc(40);
        rd(0, d); check("R8 t0 stopped", d, 8'h80);
        rd(3, d); check("R9 t0 low readback", d, 8'h01);
    endtask

    task automatic t_timer1;
        logic [7:0] d;
        wr(2, 8'h40);
        wr(6, 8'h0A); wr(7, 8'h00);   // reload 5 us
        wr(8, 8'h00);
        wr(6, 8'h02);                 // no restart: period stays 5
        waitc(5 * DIV - 2);
        rd(0, d); check("R9 t1 keeps period (before)", d, 8'h80);
        waitc(1);
        rd(0, d); check("R11 t1 sets bit 6", d, 8'hC0);
        rd(1, d); check("R3 pending t1", d, 8'hC0);
        check("R6 irq on t1", {7'd0, irq}, 8'h01);
        wr(2, 8'h20);
        rd(1, d); check("R3 pending masked off", d, 8'h80);
        check("R6 irq masked", {7'd0, irq}, 8'h00);
        rd(6, d); check("R9 t1 low readback", d, 8'h02);
        wr(7, 8'h5A); rd(7, d); check("R9 t1 high readback", d, 8'h5A);
        wr(7, 8'h00); wr(6, 8'h00); wr(8, 8'h00);
        wr(1, 8'hFF);
        waitc(30);
        rd(0, d); check("R8 t1 stopped", d, 8'h80);
    endtask

    task automatic t_vblank;
        logic [7:0] d;
        wr(2, 8'h08);
        vblank = 1'b1; waitc(1);
        rd(0, d); check("R10 vblank edge", d, 8'h88);
        check("R6 irq on vblank", {7'd0, irq}, 8'h01);
        wr(1, 8'h08);
        waitc(3);
        rd(0, d); check("R10 level held no re-set", d, 8'h80);
        check("R6 irq low", {7'd0, irq}, 8'h00);
        vblank = 1'b0; waitc(1);
        addr = 4'd1; wdata = 8'h08; we = 1'b1; vblank = 1'b1;
        @(negedge clk);
        we = 1'b0;
        rd(0, d); check("R4 event wins over ack", d, 8'h88);
        vblank = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        waitc(3);
        rst_n = 1'b1;
        waitc(2);
        t_reset();
        t_mask();
        t_timer0();
        t_timer1();
        t_vblank();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule